// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the target side of a serial memory reached over a four-wire SPI link in mode 0. The link idles with the clock low. The block oversamples chip select, serial clock and serial data-in with the system clock. It gathers 8-bit groups, most significant bit first, and decodes a one-byte command at the start of each chip-select window. There are three kinds of command:

- Commands with no payload, which set or clear a write-enable latch.
- Commands followed by a single status byte, in or out.
- Memory commands, which take a two-byte address and then stream bytes into or out of an internal byte array. The address steps by one after each byte and wraps around at the end of the array.

Every write is gated by the write-enable latch. The latch is set or cleared only by its two dedicated commands. It clears itself when chip select rises at the end of any write command, and a status write cannot touch it. After reset, a power-up counter locks the block out for a parameterised number of clock cycles. A transaction whose chip-select assertion comes too early is ignored as a whole. The serial output is high-impedance outside an accepted transaction, which the block signals through an output-enable flag.

Top module: `spim_slave`

## Requirements
- R1: Serial bytes travel most significant bit first. Serial input is captured on rising SCK. `spi_miso` changes only in response to falling SCK, and each outgoing byte's first bit is presented on the falling edge that follows the previous byte's eighth rising edge.
- R2: The first byte of a transaction is the command: 0x06 latch on, 0x04 latch off, 0x05 status read, 0x01 status write, 0x03 memory read, 0x02 memory write. A status read keeps returning the status byte for as long as SCK runs.
- R3: After reset the write-enable latch is 0. Command 0x06 sets it, and status bit 1 reports it (1 = writes allowed).
- R4: Command 0x04 clears the latch, so a later status read shows bit 1 = 0.
- R5: A status write stores data bits 7:2 in status bits 7:2. Status bit 1 ignores the written value, and status bit 0 always reads 0.
- R6: When chip select rises after a 0x01 or 0x02 command, the latch clears.
- R7: If the latch is 0 when a 0x01 or 0x02 command arrives, no status bit and no memory byte changes.
- R8: Memory commands take a 16-bit big-endian address, and only its low log2(DEPTH) bits are used. The address advances by one per data byte and wraps from DEPTH-1 to 0.
- R9: Count clock edges after reset release, numbering the first one 1. If chip select is first sampled low at edge n with n < PWRUP_CYCLES, the whole transaction is ignored. If n >= PWRUP_CYCLES, it is accepted.
- R10: `spi_miso_oe` is 0 in reset. It goes to 1 on the edge after the one that first samples chip select low for an accepted transaction. It returns to 0 on the edge after the one that first samples chip select high.
- R11: A command byte outside the six listed is ignored, along with every later byte until chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means high-impedance |

## Verification
The end of the power-up lockout and the detection of a chip-select assertion can land on the same clock. The bench provokes this with two separate resets: in one, chip select is first sampled exactly one edge before the limit, and in the other exactly at the limit. Each attempt issues command 0x06. The outcome is judged by a later status read (bit 1 must be 0, then 1) and by the per-clock output-enable model. A second coincidence, a burst write committing a byte at the same moment the address wraps to zero, is judged by reading back across the wrap with a different unused upper address byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BW = 8;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_SRD, ST_SWR, ST_SKIP
  } spim_state_t;

  localparam logic [BW-1:0] OP_WEN   = 8'h06;
  localparam logic [BW-1:0] OP_WDIS  = 8'h04;
  localparam logic [BW-1:0] OP_RSTAT = 8'h05;
  localparam logic [BW-1:0] OP_WSTAT = 8'h01;
  localparam logic [BW-1:0] OP_RMEM  = 8'h03;
  localparam logic [BW-1:0] OP_WMEM  = 8'h02;
endpackage

// File: rtl/spim_front.sv
module spim_front #(
  parameter int PWRUP_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic active,
  output logic ready,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int CW = $clog2(PWRUP_CYCLES + 2);
  localparam logic [CW-1:0] PU_LAST = CW'(PWRUP_CYCLES);

  logic [CW-1:0] pu_cnt;
  logic cs_r, cs_d, sck_r, sck_d, act_q;

  assign ready = (pu_cnt == PU_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pu_cnt <= '0;
      cs_r   <= 1'b1;
      cs_d   <= 1'b1;
      sck_r  <= 1'b0;
      sck_d  <= 1'b0;
      mosi_s <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      cs_r   <= cs_n;
      cs_d   <= cs_r;
      sck_r  <= sck;
      sck_d  <= sck_r;
      mosi_s <= mosi;
      if (!ready) pu_cnt <= pu_cnt + CW'(1);
      // a window is accepted only if the lockout is over when it opens
      if (cs_r) act_q <= 1'b0;
      else if (cs_d && ready) act_q <= 1'b1;
    end
  end

  assign active   = act_q;
  assign sck_rise = act_q & sck_r & ~sck_d;
  assign sck_fall = act_q & ~sck_r & sck_d;
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi,
  input  logic [BW-1:0] tx_byte,
  output logic          byte_valid,
  output logic [BW-1:0] rx_byte,
  output logic          miso
);
  localparam int CNTW = $clog2(BW);

  logic [CNTW-1:0] bit_cnt;
  logic [BW-1:0]   rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      miso       <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[BW-2:0], mosi};
          bit_cnt <= bit_cnt + CNTW'(1);
          if (bit_cnt == CNTW'(BW - 1)) begin
            byte_valid <= 1'b1;
            rx_byte    <= {rx_sh[BW-2:0], mosi};
          end
        end
        if (sck_fall) begin
          // byte boundary: present the MSB of the next outgoing byte
          if (bit_cnt == '0) begin
            miso  <= tx_byte[BW-1];
            tx_sh <= {tx_byte[BW-2:0], 1'b0};
          end else begin
            miso  <= tx_sh[BW-1];
            tx_sh <= {tx_sh[BW-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     active,
  input  logic                     byte_valid,
  input  logic [BW-1:0]            rx_byte,
  input  logic [BW-1:0]            rd_data,
  output logic [BW-1:0]            tx_byte,
  output logic                     wel,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  output logic [BW-1:0]            mem_wdata,
  output logic                     in_opc
);
  localparam int AW = $clog2(DEPTH);

  spim_state_t st;
  logic          wr_ok, wr_cmd;
  logic [BW-1:0] a_hi;
  logic [5:0]    sr_bits;
  logic [AW-1:0] addr;
  logic [BW-1:0] status;

  assign status    = {sr_bits, wel, 1'b0};
  assign tx_byte   = (st == ST_SRD) ? status : ((st == ST_RD) ? rd_data : '0);
  assign mem_we    = byte_valid && (st == ST_WR) && wr_ok;
  assign mem_addr  = addr;
  assign mem_wdata = rx_byte;
  assign in_opc    = (st == ST_OPC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OPC;
      wel     <= 1'b0;
      wr_ok   <= 1'b0;
      wr_cmd  <= 1'b0;
      a_hi    <= '0;
      sr_bits <= '0;
      addr    <= '0;
    end else if (!active) begin
      st     <= ST_OPC;
      wr_ok  <= 1'b0;
      wr_cmd <= 1'b0;
      if (wr_cmd) wel <= 1'b0;   // end of any write window drops the latch
    end else if (byte_valid) begin
      case (st)
        ST_OPC: begin
          case (rx_byte)
            OP_WEN:   begin wel <= 1'b1; st <= ST_SKIP; end
            OP_WDIS:  begin wel <= 1'b0; st <= ST_SKIP; end
            OP_RSTAT: st <= ST_SRD;
            OP_WSTAT: begin st <= ST_SWR; wr_cmd <= 1'b1; wr_ok <= wel; end
            OP_RMEM:  begin st <= ST_AHI; wr_cmd <= 1'b0; end
            OP_WMEM:  begin st <= ST_AHI; wr_cmd <= 1'b1; wr_ok <= wel; end
            default:  st <= ST_SKIP;
          endcase
        end
        ST_AHI: begin a_hi <= rx_byte; st <= ST_ALO; end
        ST_ALO: begin
          addr <= AW'({a_hi, rx_byte});
          st   <= wr_cmd ? ST_WR : ST_RD;
        end
        ST_RD, ST_WR: addr <= addr + AW'(1);
        ST_SWR: begin
          if (wr_ok) sr_bits <= rx_byte[7:2];
          st <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spim_ram.sv
module spim_ram
  import spim_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [BW-1:0]            wdata,
  output logic [BW-1:0]            rd_q
);
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rd_q <= mem[addr];
  end
endmodule

// File: rtl/spim_slave.sv
module spim_slave
  import spim_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int PWRUP_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          fe_active, fe_ready, fe_rise, fe_fall, fe_mosi;
  logic          sh_valid;
  logic [BW-1:0] sh_byte, ct_tx, ct_wdata, rm_q;
  logic          ct_wel, ct_we, ct_in_opc;
  logic [AW-1:0] ct_addr;

  spim_front #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_front (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .active(fe_active), .ready(fe_ready), .sck_rise(fe_rise),
    .sck_fall(fe_fall), .mosi_s(fe_mosi)
  );

  spim_shift u_shift (
    .clk(clk), .rst(rst), .active(fe_active), .sck_rise(fe_rise),
    .sck_fall(fe_fall), .mosi(fe_mosi), .tx_byte(ct_tx),
    .byte_valid(sh_valid), .rx_byte(sh_byte), .miso(spi_miso)
  );

  spim_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .active(fe_active), .byte_valid(sh_valid),
    .rx_byte(sh_byte), .rd_data(rm_q), .tx_byte(ct_tx), .wel(ct_wel),
    .mem_we(ct_we), .mem_addr(ct_addr), .mem_wdata(ct_wdata),
    .in_opc(ct_in_opc)
  );

  spim_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ct_we), .addr(ct_addr), .wdata(ct_wdata), .rd_q(rm_q)
  );

  assign spi_miso_oe = fe_active;
endmodule

// File: rtl/spim_slave_chk.sv
module spim_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       spi_miso_oe,
  input logic       ready,
  input logic       wel,
  input logic       mem_we,
  input logic       sck_fall,
  input logic       byte_valid,
  input logic [7:0] rx_byte,
  input logic       in_opc
);
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $past(spi_cs_n, 2) |-> !spi_miso_oe);

  p_wel_locked_r9: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (!wel && !spi_miso_oe));

  p_wel_set_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(byte_valid && in_opc && rx_byte == 8'h06));

  p_wr_gated_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel);

  p_miso_fall_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(sck_fall) |-> $stable(spi_miso));
endmodule

bind spim_slave spim_slave_chk u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .spi_miso_oe(spi_miso_oe), .ready(fe_ready), .wel(ct_wel),
  .mem_we(ct_we), .sck_fall(fe_fall), .byte_valid(sh_valid),
  .rx_byte(sh_byte), .in_opc(ct_in_opc)
);

// File: tb/spim_slave_test.sv
module spim_slave_test;
  localparam int P     = 40;
  localparam int DEPTH = 256;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  // reference state
  logic       m_wel = 1'b0;
  logic [5:0] m_sr  = '0;
  logic [7:0] bmem [DEPTH];
  int  m_cnt = 0;
  bit  m_prev = 1'b1, m_acc = 1'b0, m_oe = 1'b0;

  always #4 clk = ~clk;

  spim_slave #(.DEPTH(DEPTH), .PWRUP_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock output-enable reference (R9, R10)
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_prev <= 1'b1; m_acc <= 1'b0; m_oe <= 1'b0;
    end else begin
      m_cnt  <= m_cnt + 1;
      m_oe   <= !m_prev && m_acc;
      m_prev <= spi_cs_n;
      if (!spi_cs_n && m_prev) m_acc <= (m_cnt + 1 >= P);
    end
  end

  always @(negedge clk) if (!rst && !done) check("R10", int'(spi_miso_oe), int'(m_oe));

  task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tb[i];
      repeat (HALF) @(negedge clk);
      rb[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic open_x();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_x();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    open_x(); xfer(op, d); close_x();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  task automatic rdsr(input string req, input int nb);
    logic [7:0] d;
    open_x(); xfer(8'h05, d);
    for (int k = 0; k < nb; k++) begin
      xfer(8'h00, d);
      check(req, int'(d), int'({m_sr, m_wel, 1'b0}));
    end
    close_x();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    open_x(); xfer(8'h01, d); xfer(v, d); close_x();
    if (m_wel) m_sr = v[7:2];
    m_wel = 1'b0;
  endtask

  task automatic wrmem(input logic [15:0] a, input int nb, input logic [7:0] base);
    logic [7:0] d;
    open_x(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < nb; k++) begin
      xfer(8'(base + k * 37), d);
      if (m_wel) bmem[(int'(a) % DEPTH + k) % DEPTH] = 8'(base + k * 37);
    end
    close_x();
    m_wel = 1'b0;
  endtask

  task automatic rdmem(input logic [15:0] a, input int nb, input string req);
    logic [7:0] d;
    open_x(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < nb; k++) begin
      xfer(8'h00, d);
      check(req, int'(d), int'(bmem[(int'(a) % DEPTH + k) % DEPTH]));
    end
    close_x();
  endtask

  task automatic summary();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R10", int'(spi_miso_oe), 0);
    check("R1", int'(spi_miso), 0);
    rst = 1'b0;
    // R9: chip select first sampled at edge P-1 -> ignored
    repeat (P - 2) @(negedge clk);
    open_x(); xfer(8'h06, d); close_x();
    rdsr("R9", 1);
    // R9: chip select first sampled exactly at edge P -> accepted
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (P - 1) @(negedge clk);
    open_x(); xfer(8'h06, d); close_x();
    m_wel = 1'b1;
    rdsr("R9", 1);
    // R3 / R4
    cmd1(8'h04); rdsr("R4", 1);
    cmd1(8'h06); rdsr("R3", 1);
    // R7 memory: stored byte, then refused write
    wrmem(16'h0010, 1, 8'h12);
    rdsr("R6", 1);
    wrmem(16'h0010, 1, 8'hAA);
    rdmem(16'h0010, 1, "R7");
    rdmem(16'h0010, 1, "R1");
    // R5 status field behaviour, R2 repeated status read
    cmd1(8'h06); wrsr(8'hFF); rdsr("R5", 1);
    cmd1(8'h06); rdsr("R2", 2);
    wrsr(8'h01);
    m_wel = 1'b0;
    rdsr("R5", 1);
    cmd1(8'h06); wrsr(8'h01); rdsr("R6", 1);
    wrsr(8'h54); rdsr("R7", 1);
    // R8 burst write across the wrap, unused upper address bits
    cmd1(8'h06);
    wrmem(16'hABFE, 4, 8'h31);
    rdmem(16'h00FE, 4, "R8");
    rdmem(16'h12FF, 2, "R8");
    rdsr("R6", 1);
    // R11 unknown command swallows the rest of the window
    open_x(); xfer(8'h9C, d); xfer(8'h06, d); close_x();
    rdsr("R11", 1);
    cmd1(8'h06);
    open_x(); xfer(8'hE7, d); xfer(8'h04, d); close_x();
    rdsr("R11", 1);
    cmd1(8'h04);
    rdsr("R4", 1);
    summary();
  end
endmodule